// File: doc/BRIEF.md
# Pipelined Synchronous Burst Memory

This block is a small synchronous memory with a pipelined read path and an internal four-beat burst sequencer. Address, write data, chip enables, write controls and burst controls are all captured on the rising clock edge. Data moves over one shared bidirectional bus. A burst begins on one of two active-low start strobes. The processor-side strobe always opens a read. The controller-side strobe opens a read or a write, as the write controls select. After the start, an advance input either steps the two low address bits or holds them. A static order input picks a wrapping linear sequence or an XOR-based interleaved sequence.

Writes are byte-lane granular. The bus is driven only by a registered read result, and only while the asynchronous drive enable is low. Three chip enables support depth expansion. A start strobe seen while the part is not fully selected ends any burst in progress and leaves the bus released.

Top module: `burst_sram`

## Requirements
- R1: The part is selected only when `sel_pri_n`=0, `sel_hi`=1 and `sel_lo_n`=0. A deselect cycle happens when `ctrl_strobe_n` is 0, or when `proc_strobe_n` and `sel_pri_n` are both 0, while the part is not selected. After a deselect cycle no further beats occur until a new start, and the bus is released from the second edge after the deselect onward.
- R2: When `proc_strobe_n`=0 and `sel_pri_n`=0 on a selected part, the block loads `addr` and performs a read even if write controls are asserted. While `sel_pri_n`=1 the processor strobe is ignored.
- R3: When `ctrl_strobe_n`=0 on a selected part and no processor start applies, the block loads `addr` and reads or writes according to the write controls.
- R4: When neither strobe starts a burst during an active burst, `step_n`=0 advances the beat count by one and `step_n`=1 repeats the current beat address. A read or write is performed either way.
- R5: With `order_mode`=0, beat k of a burst starting at address A uses the low two bits (A[1:0]+k) mod 4. The upper address bits are unchanged.
- R6: With `order_mode`=1, beat k uses the low two bits A[1:0] XOR k. The upper address bits are unchanged.
- R7: `all_wr_n`=0 writes all lanes, whatever the values of `lane_wr_n` and `lane_sel_n`.
- R8: With `all_wr_n`=1 and `lane_wr_n`=0, lane i (bits 8i+7..8i of `dq`) is written only when `lane_sel_n[i]`=0. With `lane_wr_n`=1, or with every `lane_sel_n` bit high, the cycle is a read.
- R9: Data for a read sampled at edge N is driven on `dq` from just after edge N+1 until edge N+2. It is driven only while `drive_n` is 0, and `drive_n` acts without waiting for a clock.
- R10: If the access at edge N+1 is a write, the read from edge N is not driven, whatever the value of `drive_n`.
- R11: A write may follow a processor-strobe start at the next edge, as a continue or hold beat of the same burst.
- R12: A write commits at the edge where it is sampled, so a read of the same address at the next edge returns the new data.
- R13: During and right after reset the bus is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | External word address |
| proc_strobe_n | input | 1 | Processor-side burst start, active low, read only |
| ctrl_strobe_n | input | 1 | Controller-side burst start, active low |
| step_n | input | 1 | Burst advance, active low; high holds the current beat |
| sel_pri_n | input | 1 | Primary chip enable, active low; also gates the processor strobe |
| sel_hi | input | 1 | Second chip enable, active high |
| sel_lo_n | input | 1 | Third chip enable, active low |
| all_wr_n | input | 1 | Write all lanes, active low |
| lane_wr_n | input | 1 | Qualifies the per-lane enables, active low |
| lane_sel_n | input | LANES | Per-lane write enables, active low |
| drive_n | input | 1 | Asynchronous bus drive enable, active low |
| order_mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| dq | inout | LANES*LANE_W | Shared read/write data bus |

## Verification
The whole address space is first filled with global writes and then read back one word at a time. This separates storage and lane wiring from the burst logic. Bursts are then run from each of the four start offsets, in both orders and with both strobes, in two address groups, while `addr` is driven to an unrelated value on the advance beats. This shows whether the wrap stays inside the group of four, whether the upper bits are kept, and whether linear and XOR sequencing are distinct. All sixteen lane masks are written over a known background, which shows which lanes merge and that an empty mask becomes a read. Directed sequences cover each of the four deselect enable patterns, a hold mixed with steps, a processor start with write controls low, a write following a processor start, and the drive enable toggled in the middle of a cycle.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_DESEL = 2'd3
    } acc_op_e;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

    typedef struct packed {
        logic proc_n;
        logic ctrl_n;
        logic step_n;
    } strobe_t;

    typedef struct packed {
        logic pri_n;
        logic hi;
        logic lo_n;
    } enables_t;

    // Low address bits used by beat k of a burst that starts at offset start
    function automatic logic [1:0] beat_offset(input burst_order_e ord,
                                               input logic [1:0] start,
                                               input logic [1:0] k);
        return (ord == ORD_INTERLEAVE) ? (start ^ k) : (start + k);
    endfunction

    function automatic logic chip_selected(input enables_t e);
        return !e.pri_n && e.hi && !e.lo_n;
    endfunction

endpackage

// File: rtl/sbr_write_decode.sv
module sbr_write_decode #(
    parameter int LANES = 4
) (
    input  logic             all_wr_n,
    input  logic             lane_wr_n,
    input  logic [LANES-1:0] lane_sel_n,
    output logic [LANES-1:0] lane_mask,
    output logic             want_write
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_mask[g] = !all_wr_n || (!lane_wr_n && !lane_sel_n[g]);
    end

    assign want_write = |lane_mask;

endmodule

// File: rtl/sbr_burst_ctrl.sv
module sbr_burst_ctrl
    import sbr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  strobe_t           strobes,
    input  enables_t          enables,
    input  burst_order_e      order,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              want_write,
    output acc_op_e           acc_op,
    output logic [ADDR_W-1:0] acc_addr
);

    logic              active_q, active_nx;
    logic [ADDR_W-1:0] base_q, base_nx;
    logic [1:0]        cnt_q, cnt_nx;
    logic              sel, start_p, start_c;

    assign sel     = chip_selected(enables);
    assign start_p = !strobes.proc_n && !enables.pri_n;
    assign start_c = !strobes.ctrl_n;

    always_comb begin
        active_nx = active_q;
        base_nx   = base_q;
        cnt_nx    = cnt_q;
        acc_op    = ACC_IDLE;
        acc_addr  = {base_q[ADDR_W-1:2], beat_offset(order, base_q[1:0], cnt_q)};
        if (start_p || start_c) begin
            if (sel) begin
                active_nx = 1'b1;
                base_nx   = ext_addr;
                cnt_nx    = 2'd0;
                acc_addr  = ext_addr;
                acc_op    = (start_p || !want_write) ? ACC_READ : ACC_WRITE;
            end else begin
                active_nx = 1'b0;
                acc_op    = ACC_DESEL;
            end
        end else if (active_q) begin
            cnt_nx   = strobes.step_n ? cnt_q : cnt_q + 2'd1;
            acc_addr = {base_q[ADDR_W-1:2], beat_offset(order, base_q[1:0], cnt_nx)};
            acc_op   = want_write ? ACC_WRITE : ACC_READ;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            base_q   <= '0;
            cnt_q    <= '0;
        end else begin
            active_q <= active_nx;
            base_q   <= base_nx;
            cnt_q    <= cnt_nx;
        end
    end

endmodule

// File: rtl/sbr_array.sv
module sbr_array
    import sbr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_op_e           acc_op,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [LANES-1:0]  lane_mask,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rd_pend,
    output logic [DATA_W-1:0] rd_data
);

    logic [ADDR_W-1:0] rd_addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pend   <= 1'b0;
            rd_addr_q <= '0;
        end else begin
            rd_pend <= (acc_op == ACC_READ);
            if (acc_op == ACC_READ) begin
                rd_addr_q <= acc_addr;
            end
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] out_q;

        always_ff @(posedge clk) begin
            if (acc_op == ACC_WRITE && lane_mask[g]) begin
                mem[acc_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
            out_q <= mem[rd_addr_q];
        end

        assign rd_data[g*LANE_W +: LANE_W] = out_q;
    end

endmodule

// File: rtl/sbr_out_stage.sv
module sbr_out_stage
    import sbr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    rd_pend,
    input  acc_op_e acc_op,
    input  logic    drive_n,
    output logic    out_valid,
    output logic    bus_en
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= rd_pend && (acc_op != ACC_WRITE);
        end
    end

    assign bus_en = out_valid && !drive_n;

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import sbr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              proc_strobe_n,
    input  logic              ctrl_strobe_n,
    input  logic              step_n,
    input  logic              sel_pri_n,
    input  logic              sel_hi,
    input  logic              sel_lo_n,
    input  logic              all_wr_n,
    input  logic              lane_wr_n,
    input  logic [LANES-1:0]  lane_sel_n,
    input  logic              drive_n,
    input  logic              order_mode,
    inout  wire  [DATA_W-1:0] dq
);

    strobe_t           strobes;
    enables_t          enables;
    burst_order_e      order;
    logic [LANES-1:0]  lane_mask;
    logic              want_write;
    acc_op_e           acc_op;
    logic [ADDR_W-1:0] acc_addr;
    logic              rd_pend;
    logic [DATA_W-1:0] rd_data;
    logic              out_valid;
    logic              bus_en;

    assign strobes = '{proc_n: proc_strobe_n, ctrl_n: ctrl_strobe_n, step_n: step_n};
    assign enables = '{pri_n: sel_pri_n, hi: sel_hi, lo_n: sel_lo_n};
    assign order   = burst_order_e'(order_mode);

    sbr_write_decode #(.LANES(LANES)) u_wdec (
        .all_wr_n   (all_wr_n),
        .lane_wr_n  (lane_wr_n),
        .lane_sel_n (lane_sel_n),
        .lane_mask  (lane_mask),
        .want_write (want_write)
    );

    sbr_burst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .strobes    (strobes),
        .enables    (enables),
        .order      (order),
        .ext_addr   (addr),
        .want_write (want_write),
        .acc_op     (acc_op),
        .acc_addr   (acc_addr)
    );

    sbr_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk       (clk),
        .rst       (rst),
        .acc_op    (acc_op),
        .acc_addr  (acc_addr),
        .lane_mask (lane_mask),
        .wr_data   (dq),
        .rd_pend   (rd_pend),
        .rd_data   (rd_data)
    );

    sbr_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .rd_pend   (rd_pend),
        .acc_op    (acc_op),
        .drive_n   (drive_n),
        .out_valid (out_valid),
        .bus_en    (bus_en)
    );

    assign dq = bus_en ? rd_data : 'z;

endmodule

// File: rtl/sbr_checker.sv
module sbr_checker
    import sbr_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    proc_n,
    input logic    ctrl_n,
    input logic    pri_n,
    input logic    hi,
    input logic    lo_n,
    input logic    all_wr_n,
    input logic    lane_wr_n,
    input acc_op_e acc_op,
    input logic    out_valid
);

    logic selected;
    assign selected = !pri_n && hi && !lo_n;

    assert_desel_decode_R1: assert property (@(posedge clk) disable iff (rst)
        ((!ctrl_n || (!proc_n && !pri_n)) && !selected) |-> acc_op == ACC_DESEL);

    assert_desel_release_R1: assert property (@(posedge clk) disable iff (rst)
        (acc_op == ACC_DESEL) |=> ##1 !out_valid);

    assert_proc_reads_R2: assert property (@(posedge clk) disable iff (rst)
        (!proc_n && selected) |-> acc_op == ACC_READ);

    assert_ctrl_write_R3: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_n && proc_n && selected && !all_wr_n) |-> acc_op == ACC_WRITE);

    assert_no_write_R8: assert property (@(posedge clk) disable iff (rst)
        (all_wr_n && lane_wr_n) |-> acc_op != ACC_WRITE);

    assert_write_hiz_R10: assert property (@(posedge clk) disable iff (rst)
        (acc_op == ACC_WRITE) |=> !out_valid);

endmodule

bind burst_sram sbr_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .proc_n    (proc_strobe_n),
    .ctrl_n    (ctrl_strobe_n),
    .pri_n     (sel_pri_n),
    .hi        (sel_hi),
    .lo_n      (sel_lo_n),
    .all_wr_n  (all_wr_n),
    .lane_wr_n (lane_wr_n),
    .acc_op    (acc_op),
    .out_valid (out_valid)
);

// File: tb/burst_sram_test.sv
module burst_sram_test;

    localparam int CLK_P = 10;
    localparam int AW    = 6;
    localparam int NL    = 4;
    localparam int LW    = 8;
    localparam int DW    = NL * LW;
    localparam logic [DW-1:0] HIZ = '1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [AW-1:0] addr;
    logic proc_n, ctrl_n, step_n, pri_n, hi, lo_n, all_n, lwr_n, drv_n, mode;
    logic [NL-1:0] lsel_n;
    logic tb_oe;
    logic [DW-1:0] tb_dq;
    wire  [DW-1:0] dq;

    assign dq = tb_oe ? tb_dq : 'z;
    for (genvar i = 0; i < DW; i++) begin : g_pu
        pullup (dq[i]);
    end

    burst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) uut (
        .clk(clk), .rst(rst), .addr(addr),
        .proc_strobe_n(proc_n), .ctrl_strobe_n(ctrl_n), .step_n(step_n),
        .sel_pri_n(pri_n), .sel_hi(hi), .sel_lo_n(lo_n),
        .all_wr_n(all_n), .lane_wr_n(lwr_n), .lane_sel_n(lsel_n),
        .drive_n(drv_n), .order_mode(mode), .dq(dq)
    );

    always #(CLK_P/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [DW-1:0] ref_mem [1 << AW];
    logic pend_v = 0, chk_v = 0;
    logic [DW-1:0] pend_d, chk_d;
    string pend_t, chk_t;

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #(CLK_P/4);
        if (chk_v) check(chk_t, dq, chk_d);
        chk_v  = pend_v;
        chk_d  = pend_d;
        chk_t  = pend_t;
        pend_v = 0;
    endtask

    task automatic quiet();
        proc_n = 1; ctrl_n = 1; step_n = 1;
        pri_n = 0; hi = 1; lo_n = 0;
        all_n = 1; lwr_n = 1; lsel_n = '1;
        drv_n = 0; tb_oe = 0;
    endtask

    function automatic logic [DW-1:0] pat(input int a, input int s);
        return 32'h3C00_0000 ^ (a * 32'h0001_0101) ^ (s << 20);
    endfunction

    function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] b, input int k, input logic m);
        logic [1:0] o;
        o = m ? (b[1:0] ^ 2'(k)) : (b[1:0] + 2'(k));
        return {b[AW-1:2], o};
    endfunction

    task automatic expect_read(input logic [AW-1:0] a, input string t);
        pend_v = 1;
        pend_d = ref_mem[a];
        pend_t = t;
    endtask

    // controller-strobe write; glob selects the all-lane write, else lanes is the lane mask
    task automatic write_word(input logic [AW-1:0] a, input logic glob,
                              input logic [NL-1:0] lanes, input logic [DW-1:0] d);
        ctrl_n = 0; addr = a;
        if (glob) all_n = 0;
        else begin lwr_n = 0; lsel_n = ~lanes; end
        tb_oe = 1; tb_dq = d; drv_n = 1;
        for (int l = 0; l < NL; l++)
            if (glob || lanes[l]) ref_mem[a][l*LW +: LW] = d[l*LW +: LW];
        tick();
        quiet();
    endtask

    task automatic ctrl_read(input logic [AW-1:0] a, input string t);
        ctrl_n = 0; addr = a;
        expect_read(a, t);
        tick();
        quiet();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        quiet();
        addr = '0; mode = 0; tb_dq = '0;
        repeat (3) @(posedge clk);
        #(CLK_P/4);
        check("R13 bus released in reset", dq, HIZ);
        rst = 0;
        tick();
        check("R13 bus released after reset", dq, HIZ);

        // R7 global writes over the whole space, R3 single reads back
        for (int a = 0; a < (1 << AW); a++) write_word(AW'(a), 1'b1, '0, pat(a, 0));
        for (int a = 0; a < (1 << AW); a++) ctrl_read(AW'(a), "R3 R7 global write readback");
        tick();

        // R5 linear and R6 interleaved bursts from every start offset, both strobes
        for (int m = 0; m < 2; m++)
            for (int kind = 0; kind < 2; kind++)
                for (int grp = 1; grp < 8; grp += 5)
                    for (int s = 0; s < 4; s++) begin
                        logic [AW-1:0] b;
                        b = {4'(grp), 2'(s)};
                        mode = m[0];
                        if (kind == 0) proc_n = 0; else ctrl_n = 0;
                        addr = b;
                        expect_read(b, m ? "R6 interleaved beat" : "R5 linear beat");
                        tick();
                        quiet();
                        for (int k = 1; k < 4; k++) begin
                            step_n = 0; addr = ~b;
                            expect_read(beat_addr(b, k, m[0]), m ? "R6 interleaved beat" : "R5 linear beat");
                            tick();
                            quiet();
                        end
                        tick();
                    end

        // R4 hold and step mix
        mode = 0;
        ctrl_n = 0; addr = 6'b010001;
        expect_read(6'b010001, "R4 start beat");
        tick(); quiet();
        step_n = 1; expect_read(beat_addr(6'b010001, 0, 0), "R4 hold repeats"); tick(); quiet();
        step_n = 0; expect_read(beat_addr(6'b010001, 1, 0), "R4 step advances"); tick(); quiet();
        step_n = 1; expect_read(beat_addr(6'b010001, 1, 0), "R4 hold repeats"); tick(); quiet();
        step_n = 0; expect_read(beat_addr(6'b010001, 2, 0), "R4 step advances"); tick(); quiet();
        tick();

        // R1 deselect for each disabling pattern
        for (int c = 0; c < 4; c++) begin
            ctrl_n = 0; addr = 6'd8;
            expect_read(6'd8, "R1 read before deselect");
            tick(); quiet();
            case (c)
                0: begin ctrl_n = 0; pri_n = 1; end
                1: begin ctrl_n = 0; hi = 0; end
                2: begin ctrl_n = 0; lo_n = 1; end
                default: begin proc_n = 0; hi = 0; end
            endcase
            tick(); quiet();
            step_n = 0;
            tick();
            check("R1 bus released after deselect", dq, HIZ);
            tick();
            check("R1 no beats after deselect", dq, HIZ);
            quiet();
        end

        // R2 processor strobe ignored while primary enable is high
        mode = 0;
        ctrl_n = 0; addr = 6'd12;
        expect_read(6'd12, "R2 burst start");
        tick(); quiet();
        proc_n = 0; pri_n = 1; step_n = 0; addr = 6'd40;
        expect_read(beat_addr(6'd12, 1, 0), "R2 ignored processor strobe continues burst");
        tick(); quiet();
        tick();

        // R2 processor start reads even with write controls asserted
        proc_n = 0; addr = 6'd20; all_n = 0; lwr_n = 0; lsel_n = '0;
        expect_read(6'd20, "R2 processor start reads");
        tick(); quiet();
        tick();
        ctrl_read(6'd20, "R2 memory unchanged");
        tick();

        // R11 write after processor start, R10 release, R12 read of new data
        proc_n = 0; addr = 6'd30;
        tick(); quiet();
        all_n = 0; tb_oe = 1; drv_n = 1; tb_dq = pat(30, 9);
        ref_mem[30] = pat(30, 9);
        tick(); quiet();
        #1;
        check("R10 read replaced by write stays released", dq, HIZ);
        ctrl_read(6'd30, "R11 R12 write after processor start");
        tick();
        write_word(6'd31, 1'b1, '0, pat(31, 7));
        ctrl_read(6'd31, "R12 read right after write");
        tick();
        proc_n = 0; addr = 6'd32;
        tick(); quiet();
        step_n = 0; all_n = 0; tb_oe = 1; drv_n = 1; tb_dq = pat(33, 5);
        ref_mem[33] = pat(33, 5);
        tick(); quiet();
        ctrl_read(6'd33, "R11 write on advanced beat");
        tick();

        // R8 every lane mask over a known background
        for (int msk = 0; msk < (1 << NL); msk++) begin
            write_word(6'd50, 1'b1, '0, pat(50, 1));
            if (msk == 0) begin
                ctrl_n = 0; addr = 6'd50; lwr_n = 0; lsel_n = '1;
                expect_read(6'd50, "R8 empty lane mask reads");
                tick(); quiet();
            end else begin
                write_word(6'd50, 1'b0, NL'(msk), 32'h5A6B_7C8D);
            end
            ctrl_read(6'd50, "R8 lane merge");
            tick();
        end
        ctrl_n = 0; addr = 6'd50; lwr_n = 1; lsel_n = '0;
        expect_read(6'd50, "R8 lane enables ignored without qualifier");
        tick(); quiet();
        tick();
        ctrl_read(6'd50, "R8 memory unchanged");
        tick();

        // R9 latency and asynchronous drive enable
        ctrl_n = 0; hi = 0;
        tick(); quiet();
        tick();
        ctrl_n = 0; addr = 6'd45;
        tick(); quiet();
        check("R9 nothing driven one edge after read", dq, HIZ);
        tick();
        check("R9 data after second edge", dq, ref_mem[45]);
        drv_n = 1; #1;
        check("R9 drive enable off mid-cycle", dq, HIZ);
        drv_n = 0; #1;
        check("R9 drive enable on mid-cycle", dq, ref_mem[45]);
        tick();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule